// File: doc/BRIEF.md
# Real-Time Clock Register and Interrupt Block

This block is the register side of a real-time clock. It sits behind a 32-bit, word-only, little-endian bus and keeps a running seconds count. The count advances on a once-per-second strobe from the clock domain's prescaler, and software can load it directly. Beside the count the block holds a sub-second tick readback, a calibration word, an alarm word, a control word and a scratch safety-check word.

Two interrupt groups report events on their own level outputs. The clock group has a seconds source and an alarm source. The error group has a single source that records reads of offsets with no register behind them. Software never writes a mask directly. It sets and clears mask bits through separate write-one enable and disable locations, and it clears status bits by writing ones to them.

Top module: `rtc_regblk`

## Requirements
- R1: Each cycle with `pps_i` high and no set-time write adds one to the 32-bit seconds count. The count reads back at offset 0x10 and at offset 0x04, and bus writes to either offset leave it unchanged.
- R2: A write to offset 0x00 loads the seconds count with the write data. When a strobe arrives in the same cycle, the load wins and no increment happens. Offset 0x00 reads as 0.
- R3: Clock status (offset 0x20) bit 0 is set on every strobe. Bit 1 is set when the count takes a new value, by increment or by load, that equals the alarm word. Writing 1 to a status bit clears it. When an event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R4: Clock mask (offset 0x24, bits 1:0) resets to 0x3 and ignores direct writes. Writing 1s to offset 0x28 clears the matching mask bits, and writing 1s to offset 0x2C sets them. Both of these offsets read as 0.
- R5: `clk_irq_o` is high exactly when some clock status bit is set while its mask bit is clear. It follows status and mask with no added delay.
- R6: A read of an unmapped offset returns 0 and sets error status bit 0 (offset 0x30, write-1-to-clear). Unmapped offsets are 0x1C, 0x44 to 0x4C, anything above 0x50, and any address not a multiple of 4. The error mask (offset 0x34) resets to 1 and is read-only, with enable at offset 0x38 and disable at offset 0x3C. `aerr_irq_o` is high when the status bit is set and the mask bit is clear.
- R7: Control (offset 0x40) resets to 0x01000000. Only bits 31, 27:24 and 0 are writable, and all other bits read 0.
- R8: A write to offset 0x08 stores data bits 20:0 as the calibration word, which reads back at offset 0x0C with bits 31:21 zero. Offset 0x08 reads as 0.
- R9: Offset 0x14 bits 15:0 count clock cycles since the last strobe. A strobe clears the count to 0, it saturates at 0xFFFF, and bits 31:16 read 0.
- R10: Alarm (offset 0x18) and safety-check (offset 0x50) are full 32-bit read/write words that reset to 0.
- R11: Writes to unmapped offsets change no register and do not set the error status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps_i | input | 1 | One-cycle strobe, once per second |
| bus_valid_i | input | 1 | Bus access in this cycle |
| bus_write_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | ADDR_W (8) | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as the read access |
| clk_irq_o | output | 1 | Clock group interrupt level |
| aerr_irq_o | output | 1 | Address-error group interrupt level |

## Verification
The hardest cases to reach from the ports are collisions between the strobe and a bus write in the same cycle. One is a set-time load racing an increment. The other is a write-one-to-clear racing a fresh seconds event. The bench reaches both with a single operation task that raises the strobe and the write in one cycle, then reads the count and status back. The tick saturation limit is reached by idling more than 65535 cycles between strobes. The alarm match is reached both through an increment and through a load.

// File: rtl/rtc_regblk_pkg.sv
package rtc_regblk_pkg;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned CAL_W   = 21;
  localparam int unsigned CLK_SRC = 2;   // bit0 seconds, bit1 alarm
  localparam int unsigned ERR_SRC = 1;

  localparam logic [DATA_W-1:0] CTRL_RESET = 32'h0100_0000;
  localparam logic [DATA_W-1:0] CTRL_WMASK = 32'h8F00_0001;

  typedef enum logic [4:0] {
    RG_TSET, RG_TSHADOW, RG_CALW, RG_CALR, RG_NOW, RG_TICK, RG_ALARM,
    RG_CST, RG_CMSK, RG_CEN, RG_CDIS,
    RG_EST, RG_EMSK, RG_EEN, RG_EDIS,
    RG_CTRL, RG_SAFE, RG_NONE
  } reg_sel_e;

  // Map a byte offset to a register; anything else is unmapped.
  function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
    case (ofs)
      8'h00:   return RG_TSET;
      8'h04:   return RG_TSHADOW;
      8'h08:   return RG_CALW;
      8'h0C:   return RG_CALR;
      8'h10:   return RG_NOW;
      8'h14:   return RG_TICK;
      8'h18:   return RG_ALARM;
      8'h20:   return RG_CST;
      8'h24:   return RG_CMSK;
      8'h28:   return RG_CEN;
      8'h2C:   return RG_CDIS;
      8'h30:   return RG_EST;
      8'h34:   return RG_EMSK;
      8'h38:   return RG_EEN;
      8'h3C:   return RG_EDIS;
      8'h40:   return RG_CTRL;
      8'h50:   return RG_SAFE;
      default: return RG_NONE;
    endcase
  endfunction

  // Control write: only the writable field bits take the new value.
  function automatic logic [DATA_W-1:0] ctrl_merge(input logic [DATA_W-1:0] wd);
    return wd & CTRL_WMASK;
  endfunction

endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pps_i,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  load_val_i,
  input  logic [CNT_W-1:0]  alarm_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [TICK_W-1:0] tick_o,
  output logic              sec_evt_o,
  output logic              alarm_evt_o
);

  localparam logic [TICK_W-1:0] TICK_TOP = {TICK_W{1'b1}};

  logic [CNT_W-1:0]  count_q, count_nx;
  logic [TICK_W-1:0] tick_q;
  logic              cnt_changes;

  always_comb begin
    cnt_changes = load_i | pps_i;
    count_nx    = load_i ? load_val_i : count_q + 1'b1;
  end

  assign sec_evt_o   = pps_i;
  assign alarm_evt_o = cnt_changes && (count_nx == alarm_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (cnt_changes) begin
      count_q <= count_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
    end else if (pps_i) begin
      tick_q <= '0;
    end else if (tick_q != TICK_TOP) begin
      tick_q <= tick_q + 1'b1;
    end
  end

  assign count_o = count_q;
  assign tick_o  = tick_q;

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pps_i || load_i) |=> $stable(count_o));
  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pps_i && !load_i) |=> count_o == $past(count_o) + 1'b1);
  // R2
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> count_o == $past(load_val_i));
  // R9
  tick_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pps_i |=> tick_o == '0);
  // R9
  tick_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o == TICK_TOP && !pps_i) |=> tick_o == TICK_TOP);

endmodule

// File: rtl/rtc_irq_group.sv
module rtc_irq_group #(
  parameter int unsigned        NSRC     = 2,
  parameter logic [NSRC-1:0]    MASK_RST = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic            clr_we_i,
  input  logic            en_we_i,
  input  logic            dis_we_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] status_o,
  output logic [NSRC-1:0] mask_o,
  output logic            irq_o
);

  logic [NSRC-1:0] status_q, mask_q, clr_bits;

  assign clr_bits = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else begin
      status_q <= (status_q & ~clr_bits) | set_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_RST;
    end else if (en_we_i) begin
      mask_q <= mask_q & ~wdata_i;
    end else if (dis_we_i) begin
      mask_q <= mask_q | wdata_i;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & ~mask_q);

  for (genvar b = 0; b < NSRC; b++) begin : g_bit
    // R3
    sts_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_o[b]) |-> $past(clr_we_i && wdata_i[b]));
    // R3
    sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[b] |=> status_o[b]);
  end

  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_we_i || dis_we_i) |=> $stable(mask_o));
  // R5
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past((|set_i) || en_we_i));

endmodule

// File: rtl/rtc_regblk.sv
module rtc_regblk
  import rtc_regblk_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pps_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              clk_irq_o,
  output logic              aerr_irq_o
);

  reg_sel_e            sel;
  logic                in_win, wr_en, rd_en, rd_unmapped;
  logic [DATA_W-1:0]   alarm_q, ctrl_q, safe_q, count;
  logic [CAL_W-1:0]    cal_q;
  logic [TICK_W-1:0]   tick;
  logic                sec_evt, alarm_evt;
  logic [CLK_SRC-1:0]  clk_status, clk_mask;
  logic [ERR_SRC-1:0]  err_status, err_mask;

  assign in_win      = (bus_addr_i >> 8) == '0;
  assign sel         = in_win ? decode_ofs(bus_addr_i[7:0]) : RG_NONE;
  assign wr_en       = bus_valid_i &  bus_write_i;
  assign rd_en       = bus_valid_i & ~bus_write_i;
  assign rd_unmapped = rd_en && (sel == RG_NONE);

  rtc_time_core #(.CNT_W(DATA_W), .TICK_W(TICK_W)) time_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pps_i       (pps_i),
    .load_i      (wr_en && sel == RG_TSET),
    .load_val_i  (bus_wdata_i),
    .alarm_i     (alarm_q),
    .count_o     (count),
    .tick_o      (tick),
    .sec_evt_o   (sec_evt),
    .alarm_evt_o (alarm_evt)
  );

  rtc_irq_group #(.NSRC(CLK_SRC), .MASK_RST('1)) clk_grp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    ({alarm_evt, sec_evt}),
    .clr_we_i (wr_en && sel == RG_CST),
    .en_we_i  (wr_en && sel == RG_CEN),
    .dis_we_i (wr_en && sel == RG_CDIS),
    .wdata_i  (bus_wdata_i[CLK_SRC-1:0]),
    .status_o (clk_status),
    .mask_o   (clk_mask),
    .irq_o    (clk_irq_o)
  );

  rtc_irq_group #(.NSRC(ERR_SRC), .MASK_RST('1)) err_grp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (rd_unmapped),
    .clr_we_i (wr_en && sel == RG_EST),
    .en_we_i  (wr_en && sel == RG_EEN),
    .dis_we_i (wr_en && sel == RG_EDIS),
    .wdata_i  (bus_wdata_i[ERR_SRC-1:0]),
    .status_o (err_status),
    .mask_o   (err_mask),
    .irq_o    (aerr_irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= '0;
      ctrl_q  <= CTRL_RESET;
      safe_q  <= '0;
      cal_q   <= '0;
    end else if (wr_en) begin
      case (sel)
        RG_ALARM: alarm_q <= bus_wdata_i;
        RG_CTRL:  ctrl_q  <= ctrl_merge(bus_wdata_i);
        RG_SAFE:  safe_q  <= bus_wdata_i;
        RG_CALW:  cal_q   <= bus_wdata_i[CAL_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (rd_en) begin
      case (sel)
        RG_TSHADOW, RG_NOW: bus_rdata_o = count;
        RG_CALR:  bus_rdata_o = DATA_W'(cal_q);
        RG_TICK:  bus_rdata_o = DATA_W'(tick);
        RG_ALARM: bus_rdata_o = alarm_q;
        RG_CST:   bus_rdata_o = DATA_W'(clk_status);
        RG_CMSK:  bus_rdata_o = DATA_W'(clk_mask);
        RG_EST:   bus_rdata_o = DATA_W'(err_status);
        RG_EMSK:  bus_rdata_o = DATA_W'(err_mask);
        RG_CTRL:  bus_rdata_o = ctrl_q;
        RG_SAFE:  bus_rdata_o = safe_q;
        default:  bus_rdata_o = '0;
      endcase
    end
  end

  // R6
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |=> err_status[0]);
  // R7
  ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == RG_CTRL) |=> $stable(ctrl_q));
  // R10
  alarm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == RG_ALARM) |=> $stable(alarm_q));

endmodule

// File: tb/rtc_regblk_tb_top.sv
module rtc_regblk_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pps = 1'b0;
  logic        valid = 1'b0;
  logic        write = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        clk_irq, aerr_irq;

  int applied = 0;
  int fails   = 0;

  always #5 clk = ~clk;

  rtc_regblk dut_i (
    .clk(clk), .rst_n(rst_n), .pps_i(pps),
    .bus_valid_i(valid), .bus_write_i(write), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .clk_irq_o(clk_irq), .aerr_irq_o(aerr_irq)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  ofs;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h24, 32'h0,        32'h0000_0003, 4'd4},  // R4 mask reset
    '{1'b0, 8'h34, 32'h0,        32'h0000_0001, 4'd6},  // R6 error mask reset
    '{1'b0, 8'h40, 32'h0,        32'h0100_0000, 4'd7},  // R7 control reset
    '{1'b0, 8'h20, 32'h0,        32'h0,         4'd3},  // R3 status reset
    '{1'b0, 8'h10, 32'h0,        32'h0,         4'd1},  // R1 count reset
    '{1'b0, 8'h18, 32'h0,        32'h0,         4'd10}, // R10 alarm reset
    '{1'b1, 8'h40, 32'hFFFF_FFFF, 32'h0,        4'd7},
    '{1'b0, 8'h40, 32'h0,        32'h8F00_0001, 4'd7},  // R7 reserved bits
    '{1'b1, 8'h08, 32'hFFFF_FFFF, 32'h0,        4'd8},
    '{1'b0, 8'h0C, 32'h0,        32'h001F_FFFF, 4'd8},  // R8 readback
    '{1'b0, 8'h08, 32'h0,        32'h0,         4'd8},  // R8 write side reads 0
    '{1'b1, 8'h18, 32'hDEAD_BEEF, 32'h0,        4'd10},
    '{1'b0, 8'h18, 32'h0,        32'hDEAD_BEEF, 4'd10}, // R10 alarm rw
    '{1'b1, 8'h50, 32'h1234_5678, 32'h0,        4'd10},
    '{1'b0, 8'h50, 32'h0,        32'h1234_5678, 4'd10}, // R10 safety rw
    '{1'b1, 8'h24, 32'h0,        32'h0,         4'd4},
    '{1'b0, 8'h24, 32'h0,        32'h0000_0003, 4'd4},  // R4 direct write ignored
    '{1'b1, 8'h10, 32'h0000_0055, 32'h0,        4'd1},
    '{1'b0, 8'h10, 32'h0,        32'h0,         4'd1},  // R1 write ignored
    '{1'b0, 8'h04, 32'h0,        32'h0,         4'd1},  // R1 shadow read
    '{1'b1, 8'h28, 32'h0000_0001, 32'h0,        4'd4},
    '{1'b0, 8'h24, 32'h0,        32'h0000_0002, 4'd4},  // R4 enable clears bit0
    '{1'b0, 8'h28, 32'h0,        32'h0,         4'd4},  // R4 enable reads 0
    '{1'b1, 8'h2C, 32'h0000_0003, 32'h0,        4'd4},
    '{1'b0, 8'h24, 32'h0,        32'h0000_0003, 4'd4},  // R4 disable sets
    '{1'b1, 8'h44, 32'hFFFF_FFFF, 32'h0,        4'd11},
    '{1'b0, 8'h30, 32'h0,        32'h0,         4'd11}, // R11 no error on write
    '{1'b1, 8'h40, 32'h0,        32'h0,         4'd7},
    '{1'b0, 8'h40, 32'h0,        32'h0,         4'd7}   // R7 clear writable bits
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // One bus cycle, optionally together with a strobe; read data captured mid-cycle.
  task automatic op(input bit v, input bit w, input logic [7:0] a,
                    input logic [31:0] d, input bit p, output logic [31:0] rd);
    @(negedge clk);
    valid = v; write = w; addr = a; wdata = d; pps = p;
    #1 rd = rdata;
    @(negedge clk);
    valid = 1'b0; write = 1'b0; pps = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] unused_rd;
    op(1'b1, 1'b1, a, d, 1'b0, unused_rd);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    op(1'b1, 1'b0, a, 32'h0, 1'b0, d);
  endtask

  task automatic strobe();
    logic [31:0] unused_rd;
    op(1'b0, 1'b0, 8'h00, 32'h0, 1'b1, unused_rd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    applied++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R5 clk_irq after reset", {31'b0, clk_irq}, 32'h0);
    check("R6 aerr_irq after reset", {31'b0, aerr_irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) begin
        wr(VECS[i].ofs, VECS[i].data);
      end else begin
        rd(VECS[i].ofs, r);
        check($sformatf("R%0d table[%0d]", VECS[i].req, i), r, VECS[i].exp);
      end
    end

    // R2 load and readback
    wr(8'h00, 32'd10);
    rd(8'h10, r); check("R2 loaded count", r, 32'd10);
    rd(8'h04, r); check("R1 shadow count", r, 32'd10);
    rd(8'h00, r); check("R2 set-time reads 0", r, 32'h0);

    // R1 increment, R3 seconds status, R9 tick cleared
    wr(8'h20, 32'h3);
    strobe();
    rd(8'h14, r); check("R9 tick after strobe", r, 32'd1);
    rd(8'h10, r); check("R1 increment", r, 32'd11);
    rd(8'h20, r); check("R3 seconds bit", r, 32'h1);

    // R3 alarm on increment, R5 interrupt
    wr(8'h18, 32'd13);
    wr(8'h20, 32'h3);
    strobe();
    rd(8'h20, r); check("R3 no alarm at 12", r, 32'h1);
    strobe();
    rd(8'h20, r); check("R3 alarm at 13", r, 32'h3);
    check("R5 irq low while masked", {31'b0, clk_irq}, 32'h0);
    wr(8'h28, 32'h2);
    check("R5 irq high after enable", {31'b0, clk_irq}, 32'h1);
    wr(8'h20, 32'h2);
    check("R5 irq low after clear", {31'b0, clk_irq}, 32'h0);
    rd(8'h20, r); check("R3 W1C alarm only", r, 32'h1);

    // R2 load beats strobe; R3 alarm on load
    wr(8'h18, 32'd100);
    wr(8'h20, 32'h3);
    op(1'b1, 1'b1, 8'h00, 32'd100, 1'b1, r);
    rd(8'h10, r); check("R2 load wins over strobe", r, 32'd100);
    rd(8'h20, r); check("R3 alarm on load", r, 32'h3);
    check("R5 irq from alarm", {31'b0, clk_irq}, 32'h1);

    // R3 event wins over same-cycle clear
    op(1'b1, 1'b1, 8'h20, 32'h1, 1'b1, r);
    rd(8'h20, r); check("R3 set beats clear", r, 32'h3);
    rd(8'h10, r); check("R1 count after strobe", r, 32'd101);

    // R6 address error group
    rd(8'h1C, r); check("R6 unmapped reads 0", r, 32'h0);
    rd(8'h30, r); check("R6 error status set", r, 32'h1);
    check("R6 aerr masked", {31'b0, aerr_irq}, 32'h0);
    wr(8'h38, 32'h1);
    check("R6 aerr after enable", {31'b0, aerr_irq}, 32'h1);
    rd(8'h38, r); check("R6 enable reads 0", r, 32'h0);
    rd(8'h34, r); check("R6 mask cleared", r, 32'h0);
    wr(8'h30, 32'h1);
    check("R6 aerr after W1C", {31'b0, aerr_irq}, 32'h0);
    rd(8'h30, r); check("R6 status cleared", r, 32'h0);
    rd(8'h02, r); check("R6 unaligned reads 0", r, 32'h0);
    check("R6 aerr on unaligned", {31'b0, aerr_irq}, 32'h1);
    rd(8'h60, r);
    rd(8'h30, r); check("R6 status after high read", r, 32'h1);
    wr(8'h3C, 32'h1);
    rd(8'h34, r); check("R6 disable sets mask", r, 32'h1);
    check("R6 aerr masked again", {31'b0, aerr_irq}, 32'h0);

    // R9 saturation
    strobe();
    repeat (70000) @(negedge clk);
    rd(8'h14, r); check("R9 tick saturates", r, 32'h0000_FFFF);

    // Reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(8'h10, r); check("R1 count after reset", r, 32'h0);
    rd(8'h24, r); check("R4 mask after reset", r, 32'h3);
    rd(8'h40, r); check("R7 control after reset", r, 32'h0100_0000);
    rd(8'h18, r); check("R10 alarm after reset", r, 32'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

endmodule